// File: doc/BRIEF.md
# Firmware Load Register Handshake

This block is a register-bus slave that lets a host push a firmware image into an on-chip, word-addressed instruction memory, one 32-bit word per handshake. The host turns the session on through a control/status register and places each word in a data register. It then raises a per-word strobe bit and polls until the hardware drops that bit again. Each accepted word goes out on a single-cycle write port with an address that advances by itself.

Clearing the enable bit closes the session. The block then raises a read-only success flag, but only when at least one word went in and none was lost past the end of the memory. The memory is outside the block: only its write port (enable, address, data) is brought out. Reads are combinational from the held state, and writes take effect at the clock edge that samples them.

Control flow sits in a four-state sequencer. IDLE means no session is running. ARMED means a session is open and waiting for a strobe. WRITE is the one cycle in which the word goes to memory. SETTLE is the second strobe-busy cycle. The transitions are: IDLE to ARMED when enable is seen set; IDLE or ARMED to WRITE on an accepted strobe; ARMED to IDLE when enable is seen clear, which closes the session; WRITE to SETTLE always; SETTLE to ARMED while enable is set; and SETTLE to IDLE when enable is clear, which also closes the session.

Top module: `fwload_regs`

## Requirements
- R1: After reset the control register (byte offset 0x250) and the data register (byte offset 0x258) read 0, and the memory write enable is low.
- R2: Control bit 0 is a host read/write enable. Writes to any control bit other than 0 and 8 have no effect. Every control bit other than 0, 4 and 8 reads 0.
- R3: A write to 0x258 stores the full word, and it reads back at 0x258. Any other offset reads 0, and writes to it change nothing.
- R4: A control write with bit 8 = 1 and bit 0 = 1 is accepted when enable was already 1 and no word is in flight. Bit 8 then reads 1 for exactly the two cycles after that write edge, and reads 0 from the third.
- R5: An accepted word drives the memory write enable high for exactly one cycle, the cycle right after the strobe write. The write data in that cycle equals the data register.
- R6: Words go to consecutive addresses starting at 0. A 0-to-1 change of control bit 0 returns the address to 0 and clears the success flag.
- R7: A strobe written while enable is 0 is ignored. This includes a write that sets bits 0 and 8 together while enable was 0. Bit 8 reads 0 and no memory write occurs.
- R8: A word accepted when the memory is full (RAM_DEPTH words written) is dropped with no memory write. Bit 8 still clears after two cycles, and the session's success is withheld.
- R9: Control bit 4 is read-only. It reads 1 from the second cycle after enable is seen cleared, but only if the session wrote at least one word and dropped none. A session with no words never sets it.
- R10: A strobe written while a word is in flight is ignored. No second memory write occurs, and the busy window is not extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | BUS_AW (12) | Register byte offset |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | DATA_W (32) | Register write data |
| bus_rdata | output | DATA_W (32) | Register read data, combinational on bus_addr |
| ram_we | output | 1 | Firmware memory write enable |
| ram_addr | output | clog2(RAM_DEPTH) | Firmware memory word address |
| ram_wdata | output | DATA_W (32) | Firmware memory write data |

## Verification
A memory write and the end of a session can fall in the same cycle. The bench provokes this by clearing enable in the control register during the WRITE cycle of a word. It judges the result in three ways: the word must still reach memory; bit 8 must read 1 with bit 0 already 0 in the SETTLE cycle; and success must read 1 one cycle later, since the word counts toward the session. A second overlap, a strobe arriving while the first is still in flight, is judged by the absence of a second write pulse.

// File: rtl/fwload_pkg.sv
package fwload_pkg;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_ARMED,
        FL_WRITE,
        FL_SETTLE
    } fl_state_e;

    localparam int EN_BIT  = 0;
    localparam int OK_BIT  = 4;
    localparam int STB_BIT = 8;

endpackage

// File: rtl/fwload_busif.sv
module fwload_busif
    import fwload_pkg::*;
#(
    parameter int                BUS_AW   = 12,
    parameter int                DATA_W   = 32,
    parameter logic [BUS_AW-1:0] CTRL_OFS = 12'h250,
    parameter logic [BUS_AW-1:0] DATA_OFS = 12'h258
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic              succ,
    output logic              en_q,
    output logic [DATA_W-1:0] data_q,
    output logic              en_rise,
    output logic              strobe_go,
    output logic [DATA_W-1:0] bus_rdata
);

    logic ctrl_hit;
    logic data_hit;

    assign ctrl_hit  = bus_we && (bus_addr == CTRL_OFS);
    assign data_hit  = bus_we && (bus_addr == DATA_OFS);
    assign en_rise   = ctrl_hit && bus_wdata[EN_BIT] && !en_q;
    assign strobe_go = ctrl_hit && bus_wdata[STB_BIT] && bus_wdata[EN_BIT]
                       && en_q && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            data_q <= '0;
        end else begin
            if (ctrl_hit) en_q <= bus_wdata[EN_BIT];
            if (data_hit) data_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFS) begin
            bus_rdata[EN_BIT]  = en_q;
            bus_rdata[OK_BIT]  = succ;
            bus_rdata[STB_BIT] = busy;
        end else if (bus_addr == DATA_OFS) begin
            bus_rdata = data_q;
        end
    end

endmodule

// File: rtl/fwload_fsm.sv
module fwload_fsm
    import fwload_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic strobe_go,
    output logic wr_slot,
    output logic busy,
    output logic finish
);

    fl_state_e state_q;
    fl_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: begin
                if (strobe_go) state_d = FL_WRITE;
                else if (en_q) state_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (strobe_go)  state_d = FL_WRITE;
                else if (!en_q) state_d = FL_IDLE;
            end
            FL_WRITE:  state_d = FL_SETTLE;
            FL_SETTLE: state_d = en_q ? FL_ARMED : FL_IDLE;
        endcase
    end

    always_comb begin
        wr_slot = 1'b0;
        busy    = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            FL_IDLE:   ;
            FL_ARMED:  finish = !en_q && !strobe_go;
            FL_WRITE: begin
                wr_slot = 1'b1;
                busy    = 1'b1;
            end
            FL_SETTLE: begin
                busy   = 1'b1;
                finish = !en_q;
            end
        endcase
    end

endmodule

// File: rtl/fwload_wrptr.sv
module fwload_wrptr #(
    parameter int DATA_W    = 32,
    parameter int RAM_DEPTH = 16,
    localparam int AW = $clog2(RAM_DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_rise,
    input  logic              wr_slot,
    input  logic              finish,
    input  logic [DATA_W-1:0] data_q,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              succ_q,
    output logic              ovf_q,
    output logic [CW-1:0]     cnt_q
);

    logic full;

    assign full      = (cnt_q == CW'(RAM_DEPTH));
    assign ram_we    = wr_slot && !full;
    assign ram_addr  = cnt_q[AW-1:0];
    assign ram_wdata = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            succ_q <= 1'b0;
        end else if (en_rise) begin
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            succ_q <= 1'b0;
        end else begin
            if (wr_slot) begin
                if (full) ovf_q <= 1'b1;
                else      cnt_q <= cnt_q + 1'b1;
            end
            if (finish) succ_q <= (cnt_q != '0) && !ovf_q;
        end
    end

endmodule

// File: rtl/fwload_regs.sv
module fwload_regs
    import fwload_pkg::*;
#(
    parameter int                BUS_AW    = 12,
    parameter int                DATA_W    = 32,
    parameter int                RAM_DEPTH = 16,
    parameter logic [BUS_AW-1:0] CTRL_OFS  = 12'h250,
    parameter logic [BUS_AW-1:0] DATA_OFS  = 12'h258
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [BUS_AW-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         ram_we,
    output logic [$clog2(RAM_DEPTH)-1:0] ram_addr,
    output logic [DATA_W-1:0]            ram_wdata
);

    localparam int AW = $clog2(RAM_DEPTH);
    localparam int CW = AW + 1;

    logic              en_q;
    logic              en_rise;
    logic              strobe_go;
    logic [DATA_W-1:0] data_q;
    logic              wr_slot;
    logic              strobe_busy;
    logic              finish;
    logic              succ_q;
    logic              ovf_q;
    logic [CW-1:0]     cnt_q;

    fwload_busif #(
        .BUS_AW  (BUS_AW),
        .DATA_W  (DATA_W),
        .CTRL_OFS(CTRL_OFS),
        .DATA_OFS(DATA_OFS)
    ) u_busif (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .busy     (strobe_busy),
        .succ     (succ_q),
        .en_q     (en_q),
        .data_q   (data_q),
        .en_rise  (en_rise),
        .strobe_go(strobe_go),
        .bus_rdata(bus_rdata)
    );

    fwload_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_q     (en_q),
        .strobe_go(strobe_go),
        .wr_slot  (wr_slot),
        .busy     (strobe_busy),
        .finish   (finish)
    );

    fwload_wrptr #(
        .DATA_W   (DATA_W),
        .RAM_DEPTH(RAM_DEPTH)
    ) u_wrptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_rise  (en_rise),
        .wr_slot  (wr_slot),
        .finish   (finish),
        .data_q   (data_q),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .ram_wdata(ram_wdata),
        .succ_q   (succ_q),
        .ovf_q    (ovf_q),
        .cnt_q    (cnt_q)
    );

endmodule

// File: rtl/fwload_chk.sv
module fwload_chk #(
    parameter int RAM_DEPTH = 16,
    localparam int CW = $clog2(RAM_DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ram_we,
    input logic          busy,
    input logic          en_q,
    input logic          succ_q,
    input logic          ovf_q,
    input logic [CW-1:0] cnt_q
);

    assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cnt_q < CW'(RAM_DEPTH)));

    assert_dropped_after_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> !ram_we);

    assert_busy_enters_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    assert_busy_two_cycles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    assert_success_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(succ_q) |-> (!en_q && !ovf_q && (cnt_q != '0)));

    assert_enable_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> ((cnt_q == '0) && !succ_q && !ovf_q));

endmodule

bind fwload_regs fwload_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ram_we(ram_we),
    .busy  (strobe_busy),
    .en_q  (en_q),
    .succ_q(succ_q),
    .ovf_q (ovf_q),
    .cnt_q (cnt_q)
);

// File: tb/test_fwload_regs.sv
module test_fwload_regs;

    localparam int          DEPTH = 16;
    localparam logic [11:0] CTRL  = 12'h250;
    localparam logic [11:0] DATA  = 12'h258;
    localparam int          NV    = 6;
    localparam logic [31:0] VEC [NV] = '{32'hDEADBEEF, 32'h00000000, 32'hFFFFFFFF,
                                         32'h12345678, 32'hA5A55A5A, 32'h00000001};

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        ram_we;
    logic [3:0]  ram_addr;
    logic [31:0] ram_wdata;

    int total = 0;
    int bad = 0;
    int wr_count = 0;
    bit done = 0;
    logic [31:0] mem [DEPTH];

    always #10 clk = ~clk;

    fwload_regs #(.RAM_DEPTH(DEPTH)) i_fwload_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic send_word(input logic [31:0] w, input int idx, input bit exp_wr);
        logic [31:0] r;
        bus_wr(DATA, w);
        bus_wr(CTRL, 32'h101);
        rd(CTRL, r); chk("R4 strobe reads 1 in first cycle", r, 32'h101);
        if (exp_wr) begin
            chk("R5 write pulse", 32'(ram_we), 32'd1);
            chk("R6 word address", 32'(ram_addr), 32'(idx));
            chk("R5 write data", ram_wdata, w);
        end else begin
            chk("R8 dropped word makes no write", 32'(ram_we), 32'd0);
        end
        tick();
        chk("R5 pulse lasts one cycle", 32'(ram_we), 32'd0);
        rd(CTRL, r); chk("R4 strobe reads 1 in second cycle", r, 32'h101);
        tick();
        rd(CTRL, r); chk("R4 strobe cleared in third cycle", r, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CTRL, r); chk("R1 control after reset", r, 32'h0);
        rd(DATA, r); chk("R1 data after reset", r, 32'h0);
        chk("R1 write enable after reset", 32'(ram_we), 32'd0);

        // R2 only bit 0 is host-writable; other bits read 0
        bus_wr(CTRL, 32'hFFFF_FEEE);
        rd(CTRL, r); chk("R2 other bits ignored", r, 32'h0);
        bus_wr(CTRL, 32'h0000_0011);
        rd(CTRL, r); chk("R2/R9 enable set, bit 4 read-only", r, 32'h1);
        tick();
        bus_wr(CTRL, 32'h0);
        tick();
        rd(CTRL, r); chk("R9 empty session gives no success", r, 32'h0);

        // R7 strobe while disabled
        bus_wr(CTRL, 32'h100);
        rd(CTRL, r); chk("R7 strobe while disabled reads 0", r, 32'h0);
        chk("R7 no write while disabled", 32'(ram_we), 32'd0);
        bus_wr(CTRL, 32'h101);
        rd(CTRL, r); chk("R7 strobe with enable rising ignored", r, 32'h1);
        chk("R7 no write on enabling strobe", 32'(ram_we), 32'd0);
        tick();
        chk("R7 still no write", 32'(ram_we), 32'd0);

        // R3 unmapped offset
        bus_wr(12'h254, 32'hFFFF_FFFF);
        rd(12'h254, r); chk("R3 unmapped reads 0", r, 32'h0);
        rd(CTRL, r); chk("R3 unmapped write leaves control", r, 32'h1);
        rd(DATA, r); chk("R3 unmapped write leaves data", r, 32'h0);

        // vector table walk
        for (int i = 0; i < NV; i++) send_word(VEC[i], i, 1'b1);
        rd(DATA, r); chk("R3 data register readback", r, VEC[NV-1]);

        // R10 strobe during a word in flight
        bus_wr(DATA, 32'hCAFE_F00D);
        bus_wr(CTRL, 32'h101);
        chk("R10 first write pulse", 32'(ram_we), 32'd1);
        chk("R10 first write address", 32'(ram_addr), 32'(NV));
        bus_wr(CTRL, 32'h101);
        chk("R10 second strobe no write", 32'(ram_we), 32'd0);
        rd(CTRL, r); chk("R10 busy in settle cycle", r, 32'h101);
        tick();
        rd(CTRL, r); chk("R10 busy not extended", r, 32'h1);
        chk("R10 write count", 32'(wr_count), 32'(NV + 1));

        // R9 end of session
        bus_wr(CTRL, 32'h0);
        rd(CTRL, r); chk("R9 success not before second cycle", r, 32'h0);
        tick();
        rd(CTRL, r); chk("R9 success after enable clear", r, 32'h10);
        for (int i = 0; i < NV; i++) chk("R5 memory content", mem[i], VEC[i]);
        chk("R5 memory content last", mem[NV], 32'hCAFE_F00D);

        // R6 re-enable restarts
        bus_wr(CTRL, 32'h1);
        rd(CTRL, r); chk("R6 re-enable clears success", r, 32'h1);
        send_word(32'h1111_0000, 0, 1'b1);

        // R8 fill and overflow
        for (int i = 1; i < DEPTH; i++) send_word(32'h2000_0000 + 32'(i), i, 1'b1);
        send_word(32'hBAD0_BAD0, 0, 1'b0);
        chk("R8 last cell intact", mem[DEPTH-1], 32'h2000_0000 + 32'(DEPTH-1));
        bus_wr(CTRL, 32'h0);
        tick();
        rd(CTRL, r); chk("R8 success withheld", r, 32'h0);

        // enable cleared in the same cycle as a memory write
        bus_wr(CTRL, 32'h1);
        bus_wr(DATA, 32'h7777_8888);
        bus_wr(CTRL, 32'h101);
        chk("R5 overlap write pulse", 32'(ram_we), 32'd1);
        chk("R6 overlap address restarted", 32'(ram_addr), 32'd0);
        bus_wr(CTRL, 32'h0);
        rd(CTRL, r); chk("R4 strobe busy after enable drop", r, 32'h100);
        tick();
        rd(CTRL, r); chk("R9 success after overlapped close", r, 32'h10);
        chk("R5 overlap memory content", mem[0], 32'h7777_8888);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule